// File: doc/BRIEF.md
# Transmit FIFO Watermark Controller

This block sits between a 16-bit host-side buffer manager and a byte-serial MAC transmitter. It holds a small byte FIFO that takes 16-bit writes and gives back one byte per read. Each write can carry one byte or two, and each can tag its final byte as the end of a frame. The block watches two thresholds. The first is the free space, counted in 2-byte transfer slots, which drives a refill request back to the buffer manager. The second is the byte count of the frame now being written, which drives a transmit-start indication to the MAC.

Transmit start rises when the frame's byte count reaches the selected start point. It also rises as soon as the frame's last byte has been stored, even if the start point has not been reached. It stays high until the transmitter acknowledges the frame start. After that acknowledgement, the remaining bytes of that frame are not counted. Counting begins again with the next frame. Writes that do not fit and reads from an empty FIFO are dropped, and each sets its own sticky error flag.

Top module: `txq_mark_ctrl`

## Requirements
- R1: After reset the FIFO is empty: fill_level 0, rd_avail 0, frame_bytes 0, tx_start 0, err_ovf 0, err_udf 0, wr_room 1, and refill_req 1.
- R2: An accepted write stores wr_data[7:0] first. It then stores wr_data[15:8] only when wr_hi_vld is 1. fill_level grows by 2 or 1 to match.
- R3: rd_data shows the oldest byte while rd_avail is 1, and rd_en removes it. rd_last is 1 only on the byte that closed a frame: the high byte of a write with wr_last, or the low byte when wr_hi_vld is 0.
- R4: refill_req is 1 exactly when (128 − fill_level)/2, rounded down, is at least the watermark. The watermark is 8, 16, 32 or 48 slots for wmark_sel 00, 01, 10 or 11.
- R5: tx_start is 1 when frame_bytes is at least the start point. The start point is 4, 16, 64 or 112 bytes for start_sel 00, 01, 10 or 11. The start_sel code 10 (64 bytes) is the intended power-on setting.
- R6: Once the last byte of a frame is accepted, tx_start is 1 whatever the value of start_sel.
- R7: tx_start stays 1 until tx_ack is sampled high. That acknowledgement clears frame_bytes and tx_start. Writes of the acknowledged frame's remaining bytes leave frame_bytes at 0. Counting resumes after that frame's last byte.
- R8: A write that needs more bytes than are free is ignored: fill_level and the stored data do not change. It sets err_ovf, which stays 1 until reset. wr_room is 1 only when at least 2 bytes are free.
- R9: A read while the FIFO is empty is ignored: fill_level and the read position do not change. It sets err_udf, which stays 1 until reset.
- R10: A write and a read in the same cycle both take effect, so fill_level changes by the bytes written minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request from the buffer manager |
| wr_data | input | 16 | Write data, low byte first |
| wr_hi_vld | input | 1 | High byte of wr_data is valid |
| wr_last | input | 1 | Final byte of this write ends the frame |
| wr_room | output | 1 | At least 2 bytes free |
| rd_en | input | 1 | Byte read from the transmitter |
| rd_data | output | 8 | Oldest stored byte |
| rd_last | output | 1 | rd_data ends a frame |
| rd_avail | output | 1 | FIFO not empty |
| wmark_sel | input | 2 | Refill watermark code |
| start_sel | input | 2 | Transmit start point code |
| tx_ack | input | 1 | Transmitter accepted the frame start |
| refill_req | output | 1 | Free slots have reached the watermark |
| tx_start | output | 1 | Transmit may begin |
| fill_level | output | 8 | Stored byte count |
| frame_bytes | output | 12 | Counted bytes of the current frame |
| err_ovf | output | 1 | Sticky: write was dropped |
| err_udf | output | 1 | Sticky: read was dropped |

## Verification
For each watermark code, the bench fills the FIFO to exactly the threshold and then one transfer past it. A design with an off-by-one comparison, or one that counts free space in bytes instead of slots, shows the wrong refill_req there. It does the same for each start code. One case completes a short frame under the largest start point, which catches a design that ignores the frame-complete override. One case writes the tail of a frame that was already acknowledged. A design that keeps counting those bytes raises tx_start again in the middle of the frame. Other cases offer a two-byte write with one byte free, read from an empty FIFO, and pair a read with a write. These catch a design that stores part of a rejected write, moves its read position without data, or drops one side of a simultaneous transfer.

// File: rtl/txq_pkg.sv
package txq_pkg;

   localparam int unsigned SLOT_BYTES = 2;

   // refill watermark in free 16-bit transfer slots
   function automatic int unsigned wmark_slots(input logic [1:0] code);
      case (code)
         2'b00:   return 8;
         2'b01:   return 16;
         2'b10:   return 32;
         default: return 48;
      endcase
   endfunction

   // transmit start point in bytes of the current frame
   function automatic int unsigned start_point(input logic [1:0] code);
      case (code)
         2'b00:   return 4;
         2'b01:   return 16;
         2'b10:   return 64;
         default: return 112;
      endcase
   endfunction

   localparam int unsigned WMARK_MAX = 48;
   localparam int unsigned START_MAX = 112;

endpackage

// File: rtl/txq_store.sv
module txq_store #(
   parameter int unsigned DEPTH  = 128,
   parameter int unsigned FILL_W = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [15:0]       wr_data,
   input  logic              wr_hi_vld,
   input  logic              wr_last,
   input  logic              rd_en,
   output logic [7:0]        rd_data,
   output logic              rd_last,
   output logic [FILL_W-1:0] fill,
   output logic              wr_room,
   output logic              rd_avail,
   output logic              wr_take,
   output logic [1:0]        wr_nb,
   output logic              err_ovf,
   output logic              err_udf
);
   localparam int unsigned AW = $clog2(DEPTH);

   initial begin
      assert ((1 << AW) == DEPTH) else $error("txq_store: DEPTH must be a power of two");
      assert (DEPTH >= 4) else $error("txq_store: DEPTH too small");
   end

   logic [8:0]        mem [DEPTH];
   logic [AW-1:0]     wp_q, rp_q, wp_nx1;
   logic [FILL_W-1:0] free_b, fill_q;
   logic [1:0]        need_b;
   logic              wr_fit, rd_take;

   always_comb begin
      free_b  = FILL_W'(DEPTH) - fill_q;
      need_b  = wr_hi_vld ? 2'd2 : 2'd1;
      wr_fit  = free_b >= FILL_W'(need_b);
      wr_take = wr_en & wr_fit;
      wr_nb   = wr_take ? need_b : 2'd0;
      rd_take = rd_en & (fill_q != '0);
      wp_nx1  = wp_q + AW'(1);
   end

   // byte storage: low byte at wp, optional high byte at wp+1
   always_ff @(posedge clk) begin
      if (wr_take) begin
         mem[wp_q] <= {wr_last & ~wr_hi_vld, wr_data[7:0]};
         if (wr_hi_vld)
            mem[wp_nx1] <= {wr_last, wr_data[15:8]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q    <= '0;
         rp_q    <= '0;
         fill_q  <= '0;
         err_ovf <= 1'b0;
         err_udf <= 1'b0;
      end else begin
         if (wr_take) wp_q <= wp_q + AW'(wr_nb);
         if (rd_take) rp_q <= rp_q + AW'(1);
         fill_q <= fill_q + FILL_W'(wr_nb) - FILL_W'(rd_take);
         if (wr_en && !wr_fit) err_ovf <= 1'b1;
         if (rd_en && fill_q == '0) err_udf <= 1'b1;
      end
   end

   assign fill     = fill_q;
   assign rd_data  = mem[rp_q][7:0];
   assign rd_last  = mem[rp_q][8];
   assign wr_room  = free_b >= FILL_W'(2);
   assign rd_avail = fill_q != '0;

   // R2: level never exceeds capacity
   a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= FILL_W'(DEPTH));
   // R8: rejected write leaves level untouched
   a_r8_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_fit && !rd_en) |=> (fill_q == $past(fill_q)));
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_ovf |=> err_ovf);
   // R9: empty read leaves level at zero
   a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && fill_q == '0 && !wr_en) |=> (fill_q == '0));
   a_r9_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_udf |=> err_udf);

endmodule

// File: rtl/txq_refill.sv
module txq_refill
   import txq_pkg::*;
#(
   parameter int unsigned DEPTH     = 128,
   parameter int unsigned FILL_W    = $clog2(DEPTH) + 1,
   parameter bit          REFILL_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FILL_W-1:0] fill,
   input  logic [1:0]        wmark_sel,
   output logic              refill_req
);
   localparam int unsigned SLOTS_TOTAL = DEPTH / SLOT_BYTES;

   initial begin
      assert (WMARK_MAX <= SLOTS_TOTAL) else $error("txq_refill: watermark exceeds capacity");
   end

   logic [FILL_W-1:0] free_slots;
   logic              hit;

   always_comb begin
      free_slots = (FILL_W'(DEPTH) - fill) >> 1;
      hit        = 32'(free_slots) >= wmark_slots(wmark_sel);
   end

   generate
      if (REFILL_REG) begin : g_reg
         logic req_q;
         always_ff @(posedge clk) begin
            if (!rst_n) req_q <= 1'b1;
            else        req_q <= hit;
         end
         assign refill_req = req_q;
      end else begin : g_comb
         assign refill_req = hit;
         // R4: a full FIFO never asks for data, an empty one always does
         a_r4_full_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (fill == FILL_W'(DEPTH)) |-> !refill_req);
         a_r4_empty_asks: assert property (@(posedge clk) disable iff (!rst_n)
            (fill == '0) |-> refill_req);
      end
   endgenerate

endmodule

// File: rtl/txq_launch.sv
module txq_launch
   import txq_pkg::*;
#(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_take,
   input  logic [1:0]       wr_nb,
   input  logic             wr_last,
   input  logic [1:0]       start_sel,
   input  logic             tx_ack,
   output logic             tx_start,
   output logic [CNT_W-1:0] frame_bytes
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   initial begin
      assert ((1 << CNT_W) > START_MAX) else $error("txq_launch: CNT_W too narrow");
   end

   logic [CNT_W-1:0] cnt_q, cnt_add;
   logic             done_q, flight_q, start_c;

   always_comb begin
      cnt_add = (cnt_q > CNT_MAX - CNT_W'(wr_nb)) ? CNT_MAX : cnt_q + CNT_W'(wr_nb);
      start_c = done_q | (32'(cnt_q) >= start_point(start_sel));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         done_q   <= 1'b0;
         flight_q <= 1'b0;
      end else if (tx_ack && start_c) begin
         done_q <= 1'b0;
         if (done_q) begin
            // frame was complete: a same-cycle write opens the next frame
            cnt_q    <= wr_take ? CNT_W'(wr_nb) : '0;
            done_q   <= wr_take & wr_last;
            flight_q <= 1'b0;
         end else begin
            cnt_q    <= '0;
            flight_q <= ~(wr_take & wr_last);
         end
      end else if (wr_take) begin
         if (flight_q) begin
            if (wr_last) flight_q <= 1'b0;
         end else begin
            cnt_q <= cnt_add;
            if (wr_last) done_q <= 1'b1;
         end
      end
   end

   assign tx_start    = start_c;
   assign frame_bytes = cnt_q;

   // R7: start holds until acknowledged (unless the start code itself moves)
   a_r7_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_start && !tx_ack) |=> (tx_start || start_sel != $past(start_sel)));
   // R7: acknowledgement empties the frame count
   a_r7_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_ack && tx_start && !wr_take) |=> (frame_bytes == '0));
   // R6: completed frame forces start
   a_r6_done_start: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_take && wr_last && !flight_q && !tx_ack) |=> tx_start);

endmodule

// File: rtl/txq_mark_ctrl.sv
module txq_mark_ctrl
   import txq_pkg::*;
#(
   parameter int unsigned DEPTH      = 128,
   parameter int unsigned CNT_W      = 12,
   parameter bit          REFILL_REG = 1'b0,
   localparam int unsigned FILL_W    = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [15:0]       wr_data,
   input  logic              wr_hi_vld,
   input  logic              wr_last,
   output logic              wr_room,
   input  logic              rd_en,
   output logic [7:0]        rd_data,
   output logic              rd_last,
   output logic              rd_avail,
   input  logic [1:0]        wmark_sel,
   input  logic [1:0]        start_sel,
   input  logic              tx_ack,
   output logic              refill_req,
   output logic              tx_start,
   output logic [FILL_W-1:0] fill_level,
   output logic [CNT_W-1:0]  frame_bytes,
   output logic              err_ovf,
   output logic              err_udf
);
   logic       wr_take;
   logic [1:0] wr_nb;

   txq_store #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_store (
      .clk, .rst_n, .wr_en, .wr_data, .wr_hi_vld, .wr_last, .rd_en,
      .rd_data, .rd_last, .fill(fill_level), .wr_room, .rd_avail,
      .wr_take, .wr_nb, .err_ovf, .err_udf
   );

   txq_refill #(.DEPTH(DEPTH), .FILL_W(FILL_W), .REFILL_REG(REFILL_REG)) u_refill (
      .clk, .rst_n, .fill(fill_level), .wmark_sel, .refill_req
   );

   txq_launch #(.CNT_W(CNT_W)) u_launch (
      .clk, .rst_n, .wr_take, .wr_nb, .wr_last, .start_sel, .tx_ack,
      .tx_start, .frame_bytes
   );

   // R10: a paired read and two-byte write nets one byte
   a_r10_paired: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_hi_vld && wr_room && rd_en && rd_avail)
      |=> (fill_level == $past(fill_level) + FILL_W'(1)));

endmodule

// File: tb/txq_mark_ctrl_bench.sv
module txq_mark_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_hi_vld = 1'b0, wr_last = 1'b0, rd_en = 1'b0, tx_ack = 1'b0;
   logic [15:0] wr_data = '0;
   logic [1:0]  wmark_sel = 2'b00, start_sel = 2'b10;
   logic        wr_room, rd_last, rd_avail, refill_req, tx_start, err_ovf, err_udf;
   logic [7:0]  rd_data, fill_level;
   logic [11:0] frame_bytes;

   int n_cmp = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   always #2.5 clk = ~clk;

   txq_mark_ctrl u_txq_mark_ctrl (
      .clk, .rst_n, .wr_en, .wr_data, .wr_hi_vld, .wr_last, .wr_room,
      .rd_en, .rd_data, .rd_last, .rd_avail, .wmark_sel, .start_sel, .tx_ack,
      .refill_req, .tx_start, .fill_level, .frame_bytes, .err_ovf, .err_udf
   );

   // {wmark_sel, start_sel, bytes written, expected refill, expected start}
   localparam logic [13:0] VEC [12] = '{
      {2'd0, 2'd0, 8'd2,   1'b1, 1'b0},
      {2'd0, 2'd0, 8'd4,   1'b1, 1'b1},
      {2'd0, 2'd1, 8'd14,  1'b1, 1'b0},
      {2'd0, 2'd1, 8'd16,  1'b1, 1'b1},
      {2'd1, 2'd2, 8'd96,  1'b1, 1'b1},
      {2'd1, 2'd3, 8'd98,  1'b0, 1'b0},
      {2'd2, 2'd2, 8'd64,  1'b1, 1'b1},
      {2'd2, 2'd3, 8'd66,  1'b0, 1'b0},
      {2'd3, 2'd1, 8'd32,  1'b1, 1'b1},
      {2'd3, 2'd2, 8'd34,  1'b0, 1'b0},
      {2'd0, 2'd3, 8'd112, 1'b1, 1'b1},
      {2'd0, 2'd3, 8'd114, 1'b0, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [15:0] d, input logic hi, input logic last);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d; wr_hi_vld = hi; wr_last = last;
      @(negedge clk);
      wr_en = 1'b0; wr_hi_vld = 1'b0; wr_last = 1'b0;
   endtask

   task automatic rd();
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk);
      tx_ack = 1'b1;
      @(negedge clk);
      tx_ack = 1'b0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1 reset state
      do_reset();
      check("R1 fill", fill_level, 0);
      check("R1 avail", rd_avail, 0);
      check("R1 frame", frame_bytes, 0);
      check("R1 start", tx_start, 0);
      check("R1 refill", refill_req, 1);
      check("R1 room", wr_room, 1);
      check("R1 errs", {err_ovf, err_udf}, 0);

      // R4 / R5 threshold vectors
      foreach (VEC[i]) begin
         do_reset();
         wmark_sel = VEC[i][13:12];
         start_sel = VEC[i][11:10];
         for (int k = 0; k < int'(VEC[i][9:2]) / 2; k++) wr(16'(k), 1'b1, 1'b0);
         check("R4 refill", refill_req, VEC[i][1]);
         check("R5 start", tx_start, VEC[i][0]);
         check("R2 fill", fill_level, VEC[i][9:2]);
      end
      wmark_sel = 2'b00;

      // R2 R3 R6 odd write then frame-closing write
      do_reset();
      start_sel = 2'b10;
      wr(16'hBBAA, 1'b0, 1'b0);
      check("R2 odd fill", fill_level, 1);
      check("R5 below", tx_start, 0);
      wr(16'hDDCC, 1'b1, 1'b1);
      check("R2 fill", fill_level, 3);
      check("R6 forced start", tx_start, 1);
      check("R3 first", {rd_last, rd_data}, 9'h0AA);
      rd();
      check("R3 second", {rd_last, rd_data}, 9'h0CC);
      rd();
      check("R3 last tag", {rd_last, rd_data}, 9'h1DD);
      rd();
      check("R3 drained", rd_avail, 0);

      // R6 with largest start code and a one-byte frame
      do_reset();
      start_sel = 2'b11;
      wr(16'h0011, 1'b0, 1'b1);
      check("R6 one byte count", frame_bytes, 1);
      check("R6 one byte start", tx_start, 1);
      check("R3 low last", {rd_last, rd_data}, 9'h111);

      // R7 acknowledge mid-frame, tail not counted
      do_reset();
      start_sel = 2'b00;
      wr(16'h0102, 1'b1, 1'b0);
      wr(16'h0304, 1'b1, 1'b0);
      check("R5 at point", tx_start, 1);
      check("R5 count", frame_bytes, 4);
      repeat (3) @(negedge clk);
      check("R7 holds", tx_start, 1);
      ack();
      check("R7 cleared start", tx_start, 0);
      check("R7 cleared count", frame_bytes, 0);
      for (int k = 0; k < 3; k++) wr(16'h1111, 1'b1, 1'b0);
      check("R7 tail start", tx_start, 0);
      check("R7 tail count", frame_bytes, 0);
      wr(16'h2222, 1'b1, 1'b1);
      check("R7 tail end", frame_bytes, 0);
      wr(16'h3333, 1'b1, 1'b0);
      wr(16'h4444, 1'b1, 1'b0);
      check("R7 resumed count", frame_bytes, 4);
      check("R7 resumed start", tx_start, 1);

      // R8 write that does not fit
      do_reset();
      start_sel = 2'b10;
      for (int k = 0; k < 63; k++) wr(16'(k + 16'h0100), 1'b1, 1'b0);
      wr(16'h00EE, 1'b0, 1'b0);
      check("R8 127", fill_level, 127);
      check("R8 room", wr_room, 0);
      check("R8 no err yet", err_ovf, 0);
      wr(16'h7777, 1'b1, 1'b0);
      check("R8 ignored fill", fill_level, 127);
      check("R8 sticky", err_ovf, 1);
      for (int k = 0; k < 126; k++) rd();
      check("R8 data kept", {rd_last, rd_data}, 9'h0EE);
      rd();
      check("R8 no stray byte", rd_avail, 0);
      check("R8 still sticky", err_ovf, 1);

      // R9 read while empty
      do_reset();
      rd();
      check("R9 fill", fill_level, 0);
      check("R9 sticky", err_udf, 1);
      wr(16'h5A3C, 1'b1, 1'b1);
      check("R9 ptr kept", {rd_last, rd_data}, 9'h03C);
      rd();
      check("R9 second", {rd_last, rd_data}, 9'h15A);
      check("R9 still sticky", err_udf, 1);

      // R10 paired read and write
      do_reset();
      wr(16'h2211, 1'b1, 1'b0);
      @(negedge clk);
      wr_en = 1'b1; wr_data = 16'h4433; wr_hi_vld = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_hi_vld = 1'b0; rd_en = 1'b0;
      check("R10 fill", fill_level, 3);
      check("R10 head", rd_data, 8'h22);

      finish_run();
   end
endmodule